// File: doc/BRIEF.md
# Blanking Level Digital Clamp

This block sits on the 8-bit digitized composite video stream. Once per line a strobe marks the back porch. While the strobe is high, the block averages the first sixteen samples into a blanking level estimate. It then shifts every sample so that the measured blanking level lands on a fixed code chosen by the broadcast format: 3Ch for the 525-line format and 40h for the 625-line format.

When the clamp is disabled, samples pass through untouched with the same pipeline delay. A small sync tip setting sets the lowest code a clamped sample may take. The most recent blanking estimate is also presented as an 8-bit status value so that software can read it back.

Top module: `blank_level_clamp`

## Requirements
- R1: With `clamp_on` low, `pix_out` equals the `pix_in` value presented two clock cycles earlier, unchanged.
- R2: With `clamp_on` high and `fmt_625` low, `pix_out` equals `pix_in - blank_level + 3Ch`, taken from the inputs two cycles earlier.
- R3: With `clamp_on` high and `fmt_625` high, the added target code is 40h instead of 3Ch.
- R4: `blank_level` becomes the integer mean, rounded down, of the first 16 samples accepted while `porch_win` is high. It updates on the clock edge that accepts the 16th sample. Further samples in the same window are ignored.
- R5: `blank_level` is held while `porch_win` is low. A window that ends before 16 samples have been accepted leaves it unchanged.
- R6: When clamping, results below the sync floor are raised to it. The floor is `tip_set` in the 525-line format and `tip_set + 4` in the 625-line format, so the default setting 3h gives 3h and 7h.
- R7: When clamping, results above FFh saturate to FFh.
- R8: After reset, `pix_out` and `blank_level` are both 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_in | input | 8 | Digitized composite sample |
| porch_win | input | 1 | High during the back porch measurement window |
| fmt_625 | input | 1 | 0: 525-line format (target 3Ch), 1: 625-line format (target 40h) |
| clamp_on | input | 1 | Enables the offset; low passes samples through |
| tip_set | input | 4 | Sync tip floor setting |
| pix_out | output | 8 | Output sample, two cycles after input |
| blank_level | output | 8 | Most recent measured blanking level |

## Verification
A ramp inside the window checks that the mean is rounded down and not rounded to nearest. An overlong window that has bright samples after its sixteenth checks that only the first sixteen samples count. A short window of bright samples and a run of out-of-window samples check that the level is held. Samples at, above and far below the measured level, in both formats, separate the two target codes from each other and from the floor. A low measured level pushes bright samples past FFh, which checks the upper saturation.

// File: rtl/blank_clamp_pkg.sv
package blank_clamp_pkg;
  localparam int PIX_W = 8;
  localparam int EXT_W = PIX_W + 3;

  // Offset a sample from the measured level onto the target code, then saturate
  function automatic logic [PIX_W-1:0] offset_sample(
    input logic [PIX_W-1:0] s,
    input logic [PIX_W-1:0] lvl,
    input logic [PIX_W-1:0] tgt,
    input logic [PIX_W-1:0] flr
  );
    logic signed [EXT_W-1:0] v;
    logic signed [EXT_W-1:0] lo;
    logic signed [EXT_W-1:0] hi;
    v  = $signed({3'b000, s}) - $signed({3'b000, lvl}) + $signed({3'b000, tgt});
    lo = $signed({3'b000, flr});
    hi = $signed({3'b000, {PIX_W{1'b1}}});
    if (v < lo)      return flr;
    else if (v > hi) return {PIX_W{1'b1}};
    else             return v[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/blank_meter.sv
module blank_meter #(
  parameter int NAVG = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [blank_clamp_pkg::PIX_W-1:0]  pix_in,
  input  logic                               porch_win,
  output logic [blank_clamp_pkg::PIX_W-1:0]  lvl
);
  import blank_clamp_pkg::*;
  localparam int AW = $clog2(NAVG);
  localparam int SW = PIX_W + AW;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(NAVG - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(NAVG);

  logic [CW-1:0] cnt;
  logic [SW-1:0] acc;
  logic [SW-1:0] acc_nxt;
  logic          take;
  logic          done;

  assign take    = porch_win && (cnt < CNT_FULL);
  assign done    = take && (cnt == CNT_LAST);
  assign acc_nxt = acc + {{AW{1'b0}}, pix_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
      lvl <= '0;
    end else if (!porch_win) begin
      cnt <= '0;
      acc <= '0;
    end else if (take) begin
      cnt <= cnt + 1'b1;
      if (done) begin
        lvl <= acc_nxt[SW-1:AW];
        acc <= '0;
      end else begin
        acc <= acc_nxt;
      end
    end
  end

  // R4
  cnt_max_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CNT_FULL);

  // R5
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !porch_win |=> $stable(lvl));
endmodule

// File: rtl/blank_offset.sv
module blank_offset #(
  parameter logic [blank_clamp_pkg::PIX_W-1:0] TGT_525  = 8'h3C,
  parameter logic [blank_clamp_pkg::PIX_W-1:0] TGT_625  = 8'h40,
  parameter logic [blank_clamp_pkg::PIX_W-1:0] TIP_LIFT = 8'h04,
  parameter int TIP_W = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [blank_clamp_pkg::PIX_W-1:0]  pix_in,
  input  logic [blank_clamp_pkg::PIX_W-1:0]  lvl,
  input  logic                               fmt_625,
  input  logic                               clamp_on,
  input  logic [TIP_W-1:0]                   tip_set,
  output logic [blank_clamp_pkg::PIX_W-1:0]  pix_out
);
  import blank_clamp_pkg::*;

  logic [PIX_W-1:0] s1_pix, s1_lvl, s1_tgt, s1_flr;
  logic             s1_on;
  logic [PIX_W-1:0] flr_in;
  logic [1:0]       fill;

  assign flr_in = {{(PIX_W-TIP_W){1'b0}}, tip_set} + (fmt_625 ? TIP_LIFT : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_pix  <= '0;
      s1_lvl  <= '0;
      s1_tgt  <= '0;
      s1_flr  <= '0;
      s1_on   <= 1'b0;
      pix_out <= '0;
      fill    <= '0;
    end else begin
      s1_pix  <= pix_in;
      s1_lvl  <= lvl;
      s1_tgt  <= fmt_625 ? TGT_625 : TGT_525;
      s1_flr  <= flr_in;
      s1_on   <= clamp_on;
      pix_out <= s1_on ? offset_sample(s1_pix, s1_lvl, s1_tgt, s1_flr) : s1_pix;
      fill    <= {fill[0], 1'b1};
    end
  end

  // R1
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill[1] && !$past(clamp_on, 2)) |-> pix_out == $past(pix_in, 2));

  // R6
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill[1] && $past(clamp_on, 2)) |-> pix_out >= $past(flr_in, 2));
endmodule

// File: rtl/blank_level_clamp.sv
module blank_level_clamp #(
  parameter int NAVG = 16,
  parameter int TIP_W = 4,
  parameter logic [7:0] TGT_525  = 8'h3C,
  parameter logic [7:0] TGT_625  = 8'h40,
  parameter logic [7:0] TIP_LIFT = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       pix_in,
  input  logic             porch_win,
  input  logic             fmt_625,
  input  logic             clamp_on,
  input  logic [TIP_W-1:0] tip_set,
  output logic [7:0]       pix_out,
  output logic [7:0]       blank_level
);
  logic [7:0] lvl_w;

  blank_meter #(.NAVG(NAVG)) meter_i (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .porch_win(porch_win), .lvl(lvl_w)
  );

  blank_offset #(
    .TGT_525(TGT_525), .TGT_625(TGT_625), .TIP_LIFT(TIP_LIFT), .TIP_W(TIP_W)
  ) offset_i (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .lvl(lvl_w), .fmt_625(fmt_625),
    .clamp_on(clamp_on), .tip_set(tip_set), .pix_out(pix_out)
  );

  assign blank_level = lvl_w;

  // R8
  rst_out_chk: assert property (@(posedge clk) $rose(rst_n) |-> (pix_out == 8'h00 && blank_level == 8'h00));
endmodule

// File: tb/blank_level_clamp_tb.sv
module blank_level_clamp_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pix_in = '0;
  logic       porch_win = 1'b0;
  logic       fmt_625 = 1'b0;
  logic       clamp_on = 1'b0;
  logic [3:0] tip_set = 4'h3;
  logic [7:0] pix_out;
  logic [7:0] blank_level;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int lvl_model = 0;

  always #5 clk = ~clk;

  blank_level_clamp dut_i (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .porch_win(porch_win), .fmt_625(fmt_625),
    .clamp_on(clamp_on), .tip_set(tip_set), .pix_out(pix_out), .blank_level(blank_level)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected below 100000", cyc);
      report();
    end
  end

  // expected clamp result written straight from R2, R3, R6, R7
  function automatic int model(input int s);
    int tgt, flr, v;
    if (!clamp_on) return s;
    tgt = fmt_625 ? 64 : 60;
    flr = tip_set + (fmt_625 ? 4 : 0);
    v = s + tgt - lvl_model;
    if (v > 255) v = 255;
    if (v < flr) v = flr;
    return v;
  endfunction

  task automatic push_check(input string req, input int s);
    @(negedge clk);
    pix_in = s[7:0];
    @(negedge clk);
    @(negedge clk);
    check(req, pix_out, model(s));
  endtask

  // drives a window of n samples; sample i = base + step*i, but from index 16 on uses late
  task automatic window(input int n, input int base, input int step, input int late);
    int sum = 0;
    @(negedge clk);
    porch_win = 1'b1;
    for (int i = 0; i < n; i++) begin
      pix_in = (i < 16) ? 8'(base + step * i) : 8'(late);
      if (i < 16) sum += base + step * i;
      @(negedge clk);
    end
    porch_win = 1'b0;
    if (n >= 16) lvl_model = sum / 16;
  endtask

  task automatic t_reset;
    check("R8 pix_out", pix_out, 0);
    check("R8 blank_level", blank_level, 0);
  endtask

  task automatic t_bypass;
    clamp_on = 1'b0;
    push_check("R1", 8'h00);
    push_check("R1", 8'h7F);
    push_check("R1", 8'hFF);
  endtask

  task automatic t_measure;
    window(16, 8'h50, 1, 0);
    check("R4 ramp mean", blank_level, 8'h57);
  endtask

  task automatic t_525;
    clamp_on = 1'b1; fmt_625 = 1'b0; tip_set = 4'h3;
    push_check("R2 at level", 8'h57);
    check("R2 value", pix_out, 8'h3C);
    push_check("R2 above", 8'h80);
  endtask

  task automatic t_625;
    fmt_625 = 1'b1;
    push_check("R3 at level", 8'h57);
    check("R3 value", pix_out, 8'h40);
    push_check("R3 above", 8'hA0);
  endtask

  task automatic t_floor;
    fmt_625 = 1'b0; tip_set = 4'h3;
    push_check("R6 525", 8'h10);
    check("R6 525 floor", pix_out, 8'h03);
    fmt_625 = 1'b1;
    push_check("R6 625", 8'h10);
    check("R6 625 floor", pix_out, 8'h07);
    fmt_625 = 1'b0; tip_set = 4'h0;
    push_check("R6 zero tip", 8'h00);
    tip_set = 4'h3;
  endtask

  task automatic t_sat;
    window(16, 8'h10, 0, 0);
    check("R4 flat mean", blank_level, 8'h10);
    fmt_625 = 1'b1;
    push_check("R7 top", 8'hFF);
    check("R7 value", pix_out, 8'hFF);
    push_check("R7 edge", 8'hCF);
  endtask

  task automatic t_hold;
    window(8, 8'h90, 0, 0);
    check("R5 short window", blank_level, 8'h10);
    @(negedge clk);
    pix_in = 8'hAA;
    repeat (5) @(negedge clk);
    check("R5 outside window", blank_level, 8'h10);
    push_check("R5 offset kept", 8'h30);
  endtask

  task automatic t_long;
    window(20, 8'h20, 0, 8'hF0);
    check("R4 first sixteen only", blank_level, 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_measure();
    t_525();
    t_625();
    t_floor();
    t_sat();
    t_hold();
    t_long();
    clamp_on = 1'b0;
    push_check("R1 after clamp", 8'h33);
    report();
  end
endmodule